// File: doc/BRIEF.md
# Dead-Time Correction Polarity Selector

This block sits beside a three-pair complementary PWM motor driver. For each pair it chooses which of the two duty-cycle value registers the dead-time distortion correction should use. The first (even) register is chosen for a current polarity of 0, and the second (odd) register for a polarity of 1. The polarity can come from one of two sources. It can be a bit written by software, or it can be a sample of that pair's current-sense pin.

A 2-bit mode input selects the source and the moment of sampling. In modes 00 and 01 the software bits are used directly. If correction is not wanted, software writes these bits once, and only one value register per pair then needs loading. In mode 10, a pair's sense pin is captured on every cycle in which both its top and bottom gate drives are off, which is the dead-time. At 0% or 100% duty there is no dead-time, so the last captured value stays. In mode 11, all pins are captured at a fixed point in the PWM cycle: the half-cycle strobe when center-aligned, or the end-of-cycle strobe when edge-aligned. This gives a fresh sample even at 0% and 100% duty.

Sense pins pass through a two-flop synchronizer before capture. The register-select outputs change only on the PWM reload strobe, so the duty value never switches in the middle of a cycle.

Top module: `dtc_polsel`

## Requirements
- R1: While rst_n is low, and after its release, sel_odd is all zeros and every captured polarity is 0.
- R2: In modes 2'b00 and 2'b01, each sel_odd bit takes the value of its sw_pol bit on a cycle with reload_strobe high (0 = even register, 1 = odd register). Sense pins and strobes have no effect in these modes.
- R3: In mode 2'b10, a pair's captured polarity takes the synchronized level of its sense_in bit on each cycle where both top_on and bot_on of that pair are 0.
- R4: In mode 2'b10, on a cycle where top_on or bot_on of a pair is 1 (including constant 0% or 100% duty), that pair's captured polarity is held.
- R5: In mode 2'b11 with center_mode=1, all pairs capture only on cycles with half_strobe high. end_strobe is ignored.
- R6: In mode 2'b11 with center_mode=0, all pairs capture only on cycles with end_strobe high. half_strobe is ignored. Capture does not depend on the gate-drive states.
- R7: The three pairs are independent. Bit i of sense_in, sw_pol, top_on and bot_on affects only bit i of sel_odd.
- R8: sel_odd changes only on the clock edge after a cycle with reload_strobe high. In modes 1x it then takes the captured polarity.
- R9: sense_in passes through two flops before capture. A level present at sense_in before edge k is capturable at edge k+2, and the resulting selection appears after the next reload edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Polarity source: 0x software, 10 dead-time capture, 11 fixed-point capture |
| center_mode | input | 1 | 1 = center-aligned PWM, 0 = edge-aligned |
| half_strobe | input | 1 | One-cycle pulse at the half-cycle point |
| end_strobe | input | 1 | One-cycle pulse at the end of the PWM cycle |
| reload_strobe | input | 1 | One-cycle pulse at the PWM reload boundary |
| top_on | input | 3 | Top switch gate-drive state per pair |
| bot_on | input | 3 | Bottom switch gate-drive state per pair |
| sense_in | input | 3 | Current-sense pin per pair (asynchronous) |
| sw_pol | input | 3 | Software polarity bit per pair |
| sel_odd | output | 3 | Per pair: 1 selects the odd value register, 0 the even one |

## Verification
On every cycle the assertions check four things. The output holds between reload strobes. In software modes the output takes sw_pol at a reload. In mode 10 the captured polarity of any pair with a switch on stays frozen. In mode 11 nothing is captured outside the strobe that matches the alignment. Only the bench's scenarios can show the rest: the exact two-flop latency from a pin to capture, that the correct pin level is captured during dead-time, and that a polarity captured long ago survives long stretches of 0% or 100% duty and finally reaches sel_odd. The bench's cycle-accurate model covers all of these under mixed per-pair patterns.

// File: rtl/dtc_polsel.sv
module dtc_polsel #(
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             center_mode,
  input  logic             half_strobe,
  input  logic             end_strobe,
  input  logic             reload_strobe,
  input  logic [NPAIR-1:0] top_on,
  input  logic [NPAIR-1:0] bot_on,
  input  logic [NPAIR-1:0] sense_in,
  input  logic [NPAIR-1:0] sw_pol,
  output logic [NPAIR-1:0] sel_odd
);
  logic [NPAIR-1:0] sync1, sync2, lat, cap_en, src;
  logic             fixed_pt;

  assign fixed_pt = center_mode ? half_strobe : end_strobe;
  assign src      = mode[1] ? lat : sw_pol;

  always_comb begin
    case (mode)
      2'b10:   cap_en = ~(top_on | bot_on);
      2'b11:   cap_en = {NPAIR{fixed_pt}};
      default: cap_en = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      lat     <= '0;
      sel_odd <= '0;
    end else begin
      sync1 <= sense_in;
      sync2 <= sync1;
      lat   <= (lat & ~cap_en) | (sync2 & cap_en);
      if (reload_strobe) sel_odd <= src;
    end
  end
endmodule

module dtc_polsel_chk #(
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             center_mode,
  input logic             half_strobe,
  input logic             end_strobe,
  input logic             reload_strobe,
  input logic [NPAIR-1:0] top_on,
  input logic [NPAIR-1:0] bot_on,
  input logic [NPAIR-1:0] sw_pol,
  input logic [NPAIR-1:0] lat,
  input logic [NPAIR-1:0] sel_odd
);
  always @(posedge clk)
    if (!rst_n) a_r1_reset_zero: assert (sel_odd == '0 && lat == '0);

  a_r8_hold_between_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_strobe |=> $stable(sel_odd));

  a_r2_software_source: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_strobe && !mode[1]) |=> sel_odd == $past(sw_pol));

  a_r2_no_capture_sw_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> $stable(lat));

  a_r4_hold_when_switch_on: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> ((lat ^ $past(lat)) & $past(top_on | bot_on)) == '0);

  a_r5_center_only_half: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && center_mode && !half_strobe) |=> $stable(lat));

  a_r6_edge_only_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !center_mode && !end_strobe) |=> $stable(lat));
endmodule

bind dtc_polsel dtc_polsel_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .center_mode(center_mode),
  .half_strobe(half_strobe), .end_strobe(end_strobe),
  .reload_strobe(reload_strobe), .top_on(top_on), .bot_on(bot_on),
  .sw_pol(sw_pol), .lat(lat), .sel_odd(sel_odd)
);

// File: tb/sim_dtc_polsel.sv
`timescale 1ns/1ps
module sim_dtc_polsel;
  logic       clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic       center_mode = 0, half_strobe = 0, end_strobe = 0, reload_strobe = 0;
  logic [2:0] top_on = 0, bot_on = 0, sense_in = 0, sw_pol = 0;
  logic [2:0] sel_odd;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  dtc_polsel u0 (.*);

  // behavioural reference: pin history queue, captured polarity, selection
  bit [2:0] hist[$];
  bit [2:0] m_pol, m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000};
      m_pol = 0; m_sel = 0;
    end else begin
      if (reload_strobe) m_sel = mode[1] ? m_pol : sw_pol;
      for (int i = 0; i < 3; i++) begin
        bit take;
        take = 0;
        if (mode == 2'b10) take = !top_on[i] && !bot_on[i];
        if (mode == 2'b11) take = center_mode ? half_strobe : end_strobe;
        if (take) m_pol[i] = hist[0][i];
      end
      void'(hist.pop_front());
      hist.push_back(sense_in);
    end
  end

  task automatic check_out();
    checks++;
    if (sel_odd !== m_sel) begin
      errors++;
      $display("FAIL %s: sel_odd=%b expected=%b at %0t", tag, sel_odd, m_sel, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check_out();

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // one PWM-like cycle of length len with strobes; gates per style
  task automatic pwm_cycle(int len, int style);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      #0.5;
      half_strobe   = (t == len/2);
      end_strobe    = (t == len-1);
      reload_strobe = (t == len-1) || (style == 3);
      sense_in      = 3'($urandom);
      sw_pol        = 3'($urandom);
      for (int i = 0; i < 3; i++) begin
        int duty;
        duty = (style == 1 && i == 0) ? 0 : (style == 1 && i == 1) ? len : 2 + i;
        if (t < duty) begin top_on[i] = 1; bot_on[i] = 0; end
        else if (t == duty || t == len-1) begin top_on[i] = 0; bot_on[i] = 0; end
        else begin top_on[i] = 0; bot_on[i] = 1; end
        if (style == 1 && i < 2) begin top_on[i] = (i == 1); bot_on[i] = (i == 0); end
      end
    end
  endtask

  initial begin
    #1;
    cyc(3);
    tag = "R1";
    checks++;
    if (sel_odd !== 3'b000) begin errors++; $display("FAIL R1: sel_odd=%b expected=000", sel_odd); end
    @(negedge clk); #0.5 rst_n = 1;
    cyc(2);
    checks++;
    if (sel_odd !== 3'b000) begin errors++; $display("FAIL R1: sel_odd=%b expected=000 after release", sel_odd); end

    tag = "R2"; mode = 2'b00;
    repeat (6) pwm_cycle(10, 0);
    mode = 2'b01;
    repeat (6) pwm_cycle(10, 0);

    tag = "R3"; mode = 2'b10; center_mode = 1;
    repeat (20) pwm_cycle(12, 0);

    tag = "R4";
    repeat (20) pwm_cycle(12, 1);

    tag = "R5"; mode = 2'b11; center_mode = 1;
    repeat (20) pwm_cycle(11, 0);
    repeat (10) pwm_cycle(11, 1);

    tag = "R6"; center_mode = 0;
    repeat (20) pwm_cycle(11, 0);
    repeat (10) pwm_cycle(11, 1);

    tag = "R7"; mode = 2'b10;
    repeat (20) pwm_cycle(9, 2);
    mode = 2'b00;
    repeat (10) pwm_cycle(9, 2);

    tag = "R8"; mode = 2'b11;
    repeat (10) pwm_cycle(13, 0);
    mode = 2'b10;
    repeat (10) pwm_cycle(7, 0);

    // R9: reload every cycle, all switches off, step sense and watch latency
    tag = "R9"; mode = 2'b10;
    @(negedge clk); #0.5;
    half_strobe = 0; end_strobe = 0; top_on = 0; bot_on = 0;
    reload_strobe = 1; sense_in = 3'b000;
    cyc(5);
    #0.5 sense_in = 3'b101;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      checks++;
      if (sel_odd !== ((k >= 4) ? 3'b101 : 3'b000)) begin
        errors++;
        $display("FAIL R9: sel_odd=%b expected=%b at step %0d", sel_odd,
                 (k >= 4) ? 3'b101 : 3'b000, k);
      end
    end
    #0.5 sense_in = 3'b010;
    repeat (30) pwm_cycle(6, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule